// File: doc/BRIEF.md
# Set-Associative Cache Controller with Age-Counter Replacement

This block is a write-through, write-allocate, set-associative cache that sits between a processor port and a slower memory level. Each lookup compares the tag of the requested word against every way of the addressed set. A hit returns the word on the next cycle. A miss stalls the processor and fetches the whole line from the lower level. The line is installed, and after a fixed miss penalty the word is delivered.

Replacement does not keep an ordering of ways. Each block instead has a small saturating age counter. Every lookup into a set makes all of that set's blocks one step older. The block that was hit, or that was just filled, goes back to age zero. On a miss the controller prefers an empty way, and otherwise it evicts the oldest block. The set count, way count, line length, age width and miss penalty are all parameters. Two running counters report how many lookups hit and how many missed.

Top module: `cache_age_lru`

## Requirements
- R1: After a synchronous reset, the block drives `cpu_ready`=1, `cpu_rvalid`=0, `mem_req`=0, `mem_wr_en`=0 and both counters at 0. All ways are empty.
- R2: A request accepted while `cpu_ready`=1 that hits returns the stored word on `cpu_rdata`, with `cpu_rvalid`=1 in the cycle right after acceptance. `cpu_ready` stays high, and `hit_count` rises by one.
- R3: A request that misses does the following. It raises `miss_count` by one. It drops `cpu_ready` from the cycle after acceptance, and `cpu_ready` stays low until the word is delivered. It holds `mem_req` high with a stable line address (word address shifted right by log2 of the line length) until `mem_rvalid` is sampled. It asserts `cpu_rvalid` and `cpu_ready` together exactly MISS_PENALTY cycles after the edge at which `mem_rvalid` was sampled high.
- R4: Every lookup raises the age of every way in the addressed set by one, and no other set is touched. Ages saturate at 2^AGE_W-1. A hit way's age is cleared at its lookup, and a filled way's age is cleared when the line arrives.
- R5: On a miss the victim is the lowest-numbered empty way if the set has one. Otherwise it is the way with the largest age, and ties go to the lowest way number. Victim selection uses the ages as they were before that lookup.
- R6: Saturation is observable. After four fills of one set and five further hits on the last-filled block, way 0 and way 1 both sit at the cap. The next miss then evicts way 0, and way 1 still hits.
- R7: Every write, hit or miss, is passed to memory. `mem_wr_en`=1 is driven with the word address and data in the same cycle as the write's `cpu_rvalid`. The cached copy holds the new data, and a write miss merges its word into the refilled line.
- R8: For a read, `cpu_rdata` equals the current memory content of the word. The address layout is: word offset in the low log2(LINE_WORDS) bits, then the set index, then the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_rvalid | output | 1 | Completion pulse; read data valid |
| cpu_rdata | output | DATA_W | Read data (write data echoed for writes) |
| mem_req | output | 1 | Line refill request |
| mem_raddr | output | ADDR_W-log2(LINE_WORDS) | Line address of refill |
| mem_rvalid | input | 1 | Refill line present (one cycle) |
| mem_rline | input | DATA_W*LINE_WORDS | Refill line, word 0 in low bits |
| mem_wr_en | output | 1 | Write-through strobe |
| mem_wr_addr | output | ADDR_W | Write-through word address |
| mem_wr_data | output | DATA_W | Write-through data |
| hit_count | output | CNT_W | Lookups that hit |
| miss_count | output | CNT_W | Lookups that missed |

## Verification
The bound checker watches several rules on every cycle. It checks that a completion never comes while stalled and that a refill request always coincides with a stall. It checks that the refill address holds steady while waiting and that a write-through strobe only appears with a completion. It also checks that each counter moves by at most one step and that every acceptance moves exactly one of them. Only the bench's scenarios can show which way gets evicted, which depends on ages accumulated over many lookups. The same holds for the exact penalty timing, returned data after merges, and the difference between a saturating and a wrapping age.

// File: rtl/cache_age_pkg.sv
package cache_age_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REFILL = 2'd1,
    ST_WAIT   = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
  parameter int WAYS  = 4,
  parameter int AGE_W = 3,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*AGE_W-1:0] way_ages,
  output logic [WAY_W-1:0]      victim
);
  logic             found;
  logic [AGE_W-1:0] best;

  always_comb begin
    found  = 1'b0;
    victim = '0;
    best   = '0;
    // empty ways win, lowest index first
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !way_valid[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    // otherwise strict compare keeps the lowest way on a tie
    if (!found) begin
      for (int w = 0; w < WAYS; w++) begin
        if (way_ages[w*AGE_W +: AGE_W] > best) begin
          best   = way_ages[w*AGE_W +: AGE_W];
          victim = WAY_W'(w);
        end
      end
    end
  end
endmodule

// File: rtl/cache_age_bank.sv
module cache_age_bank #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int AGE_W = 3,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      look_set,
  input  logic                  look_en,
  input  logic                  look_hit,
  input  logic [WAY_W-1:0]      look_way,
  input  logic                  fill_en,
  input  logic [IDX_W-1:0]      fill_set,
  input  logic [WAY_W-1:0]      fill_way,
  output logic [WAYS*AGE_W-1:0] set_ages
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age_q [SETS][WAYS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_ff @(posedge clk) begin
        if (rst) begin
          age_q[s][w] <= '0;
        end else if (look_en && look_set == IDX_W'(s)) begin
          if (look_hit && look_way == WAY_W'(w))
            age_q[s][w] <= '0;
          else if (age_q[s][w] != AGE_MAX)
            age_q[s][w] <= age_q[s][w] + 1'b1;
        end else if (fill_en && fill_set == IDX_W'(s) && fill_way == WAY_W'(w)) begin
          age_q[s][w] <= '0;
        end
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++)
      set_ages[w*AGE_W +: AGE_W] = age_q[look_set][w];
  end
endmodule

// File: rtl/cache_age_lru.sv
module cache_age_lru
  import cache_age_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 32,
  parameter int SETS         = 4,
  parameter int WAYS         = 4,
  parameter int LINE_WORDS   = 4,
  parameter int AGE_W        = 3,
  parameter int MISS_PENALTY = 20,
  parameter int CNT_W        = 16,
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int IDX_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W  = DATA_W * LINE_WORDS,
  localparam int LADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_valid,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_ready,
  output logic               cpu_rvalid,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               mem_req,
  output logic [LADDR_W-1:0] mem_raddr,
  input  logic               mem_rvalid,
  input  logic [LINE_W-1:0]  mem_rline,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_wr_addr,
  output logic [DATA_W-1:0]  mem_wr_data,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   miss_count
);
  localparam int SLOT_W = IDX_W + WAY_W;
  localparam int PEN_W  = $clog2(MISS_PENALTY + 1);

  ctl_state_e st_q;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [LINE_W-1:0] line_mem [1 << SLOT_W];

  // lookup on the incoming request
  logic [OFF_W-1:0] lk_off;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;
  logic             hit_any;
  logic             accept;
  logic [LINE_W-1:0] lk_line;
  logic [DATA_W-1:0] lk_word;

  assign lk_off = cpu_addr[OFF_W-1:0];
  assign lk_idx = cpu_addr[OFF_W +: IDX_W];
  assign lk_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign accept = (st_q == ST_IDLE) && cpu_valid;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end
  assign hit_any = |hit_vec;
  assign lk_line = line_mem[{lk_idx, hit_way}];
  assign lk_word = lk_line[lk_off*DATA_W +: DATA_W];

  // held miss request
  logic [ADDR_W-1:0] rq_addr;
  logic              rq_we;
  logic [DATA_W-1:0] rq_wdata;
  logic [WAY_W-1:0]  rq_vict;
  logic [PEN_W-1:0]  pen_q;
  logic [OFF_W-1:0]  rq_off;
  logic [IDX_W-1:0]  rq_idx;
  logic [TAG_W-1:0]  rq_tag;
  logic [LINE_W-1:0] fill_line;
  logic              fill_now;

  assign rq_off   = rq_addr[OFF_W-1:0];
  assign rq_idx   = rq_addr[OFF_W +: IDX_W];
  assign rq_tag   = rq_addr[ADDR_W-1 -: TAG_W];
  assign fill_now = (st_q == ST_REFILL) && mem_rvalid;

  always_comb begin
    fill_line = mem_rline;
    if (rq_we) fill_line[rq_off*DATA_W +: DATA_W] = rq_wdata;
  end

  logic [WAYS*AGE_W-1:0] set_ages;
  logic [WAY_W-1:0]      victim;

  cache_age_bank #(.SETS(SETS), .WAYS(WAYS), .AGE_W(AGE_W)) u_ages (
    .clk      (clk),
    .rst      (rst),
    .look_set (lk_idx),
    .look_en  (accept),
    .look_hit (hit_any),
    .look_way (hit_way),
    .fill_en  (fill_now),
    .fill_set (rq_idx),
    .fill_way (rq_vict),
    .set_ages (set_ages)
  );

  cache_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_pick (
    .way_valid (vld_q[lk_idx]),
    .way_ages  (set_ages),
    .victim    (victim)
  );

  // line storage: no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (accept && hit_any && cpu_we)
      line_mem[{lk_idx, hit_way}][lk_off*DATA_W +: DATA_W] <= cpu_wdata;
    else if (fill_now)
      line_mem[{rq_idx, rq_vict}] <= fill_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      cpu_ready   <= 1'b1;
      cpu_rvalid  <= 1'b0;
      cpu_rdata   <= '0;
      mem_req     <= 1'b0;
      mem_raddr   <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      hit_count   <= '0;
      miss_count  <= '0;
      rq_addr     <= '0;
      rq_we       <= 1'b0;
      rq_wdata    <= '0;
      rq_vict     <= '0;
      pen_q       <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
      end
    end else begin
      cpu_rvalid <= 1'b0;
      mem_wr_en  <= 1'b0;
      case (st_q)
        ST_IDLE: if (cpu_valid) begin
          if (hit_any) begin
            hit_count  <= hit_count + 1'b1;
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= cpu_we ? cpu_wdata : lk_word;
            if (cpu_we) begin
              mem_wr_en   <= 1'b1;
              mem_wr_addr <= cpu_addr;
              mem_wr_data <= cpu_wdata;
            end
          end else begin
            miss_count <= miss_count + 1'b1;
            rq_addr    <= cpu_addr;
            rq_we      <= cpu_we;
            rq_wdata   <= cpu_wdata;
            rq_vict    <= victim;
            mem_req    <= 1'b1;
            mem_raddr  <= cpu_addr[ADDR_W-1:OFF_W];
            cpu_ready  <= 1'b0;
            st_q       <= ST_REFILL;
          end
        end
        ST_REFILL: if (mem_rvalid) begin
          mem_req                 <= 1'b0;
          tag_q[rq_idx][rq_vict]  <= rq_tag;
          vld_q[rq_idx][rq_vict]  <= 1'b1;
          cpu_rdata               <= fill_line[rq_off*DATA_W +: DATA_W];
          pen_q                   <= PEN_W'(MISS_PENALTY - 1);
          st_q                    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (pen_q == '0) begin
            cpu_rvalid <= 1'b1;
            cpu_ready  <= 1'b1;
            st_q       <= ST_IDLE;
            if (rq_we) begin
              mem_wr_en   <= 1'b1;
              mem_wr_addr <= rq_addr;
              mem_wr_data <= rq_wdata;
            end
          end else begin
            pen_q <= pen_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_age_lru_chk.sv
module cache_age_lru_chk #(
  parameter int LADDR_W = 10,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_valid,
  input logic               cpu_ready,
  input logic               cpu_rvalid,
  input logic               mem_req,
  input logic               mem_rvalid,
  input logic [LADDR_W-1:0] mem_raddr,
  input logic               mem_wr_en,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   miss_count
);
  // R2, R3: a completion is never presented while the port is stalled
  p_done_ready_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> cpu_ready);

  // R3: a refill request only exists during a stall
  p_req_stall_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  // R3: the request is held with a steady line address until answered
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_raddr)));

  // R7: a write-through strobe comes with a completion
  p_wr_done_r7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> cpu_rvalid);

  // R2: the hit counter steps by one at most
  p_hit_step_r2: assert property (@(posedge clk) disable iff (rst)
    (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + 1'b1));

  // R3: the miss counter steps by one at most
  p_miss_step_r3: assert property (@(posedge clk) disable iff (rst)
    (miss_count != $past(miss_count)) |-> (miss_count == $past(miss_count) + 1'b1));

  // R2, R3: every accepted request moves exactly one counter
  p_accept_count_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready) |=>
      ((hit_count != $past(hit_count)) != (miss_count != $past(miss_count))));
endmodule

bind cache_age_lru cache_age_lru_chk #(.LADDR_W(LADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_valid  (cpu_valid),
  .cpu_ready  (cpu_ready),
  .cpu_rvalid (cpu_rvalid),
  .mem_req    (mem_req),
  .mem_rvalid (mem_rvalid),
  .mem_raddr  (mem_raddr),
  .mem_wr_en  (mem_wr_en),
  .hit_count  (hit_count),
  .miss_count (miss_count)
);

// File: tb/cache_age_lru_tb.sv
module cache_age_lru_tb;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int LWORDS  = 4;
  localparam int PENALTY = 20;
  localparam int RESP_LAT = 3;
  localparam int LADDR_W = ADDR_W - 2;
  localparam int LINE_W  = DATA_W * LWORDS;
  localparam int NWORDS  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic               cpu_valid = 1'b0;
  logic               cpu_we = 1'b0;
  logic [ADDR_W-1:0]  cpu_addr = '0;
  logic [DATA_W-1:0]  cpu_wdata = '0;
  logic               cpu_ready, cpu_rvalid;
  logic [DATA_W-1:0]  cpu_rdata;
  logic               mem_req;
  logic [LADDR_W-1:0] mem_raddr;
  logic               mem_rvalid = 1'b0;
  logic [LINE_W-1:0]  mem_rline = '0;
  logic               mem_wr_en;
  logic [ADDR_W-1:0]  mem_wr_addr;
  logic [DATA_W-1:0]  mem_wr_data;
  logic [15:0]        hit_count, miss_count;

  cache_age_lru #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LWORDS),
                  .MISS_PENALTY(PENALTY)) u_dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_raddr(mem_raddr), .mem_rvalid(mem_rvalid), .mem_rline(mem_rline),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int resp_cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [DATA_W-1:0] golden  [NWORDS];
  logic [DATA_W-1:0] backing [NWORDS];

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    bit                we;
    bit                hit;
    int                acc;
    bit                stall_bad;
    string             rq;
  } item_t;
  item_t q[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // driver: issue one request and queue what must come back
  task automatic access(input logic [ADDR_W-1:0] a, input bit we,
                        input logic [DATA_W-1:0] d, input bit hit, input string rq);
    item_t it;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (we) golden[a] = d;
    it.addr = a; it.we = we; it.hit = hit; it.acc = cyc + 1;
    it.data = golden[a]; it.stall_bad = 1'b0; it.rq = rq;
    q.push_back(it);
    @(negedge clk);
    cpu_valid = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_counts(input int h, input int m, input string rq);
    chk(hit_count == 16'(h), rq, "hit_count", 32'(hit_count), 32'(h));
    chk(miss_count == 16'(m), rq, "miss_count", 32'(miss_count), 32'(m));
  endtask

  // lower-level responder with fixed latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        repeat (RESP_LAT) @(negedge clk);
        for (int w = 0; w < LWORDS; w++)
          mem_rline[w*DATA_W +: DATA_W] = backing[{mem_raddr, 2'(w)}];
        mem_rvalid = 1'b1;
        resp_cyc = cyc + 1;
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (cpu_rvalid) begin
          if (q.size() == 0) begin
            chk(1'b0, "R2", "unexpected completion", 32'(cpu_rdata), 32'h0);
          end else begin
            item_t it;
            it = q.pop_front();
            chk(cpu_rdata == it.data, "R8", $sformatf("data @%0h", it.addr), cpu_rdata, it.data);
            chk(cpu_ready, it.rq, "ready with completion", 32'(cpu_ready), 32'h1);
            if (it.hit)
              chk(cyc == it.acc, "R2", $sformatf("hit timing @%0h", it.addr), 32'(cyc), 32'(it.acc));
            else begin
              chk(resp_cyc > it.acc && cyc == resp_cyc + PENALTY, "R3",
                  $sformatf("miss timing @%0h", it.addr), 32'(cyc), 32'(resp_cyc + PENALTY));
              chk(!it.stall_bad, "R3", "ready high during stall", 32'(it.stall_bad), 32'h0);
            end
            if (it.we) begin
              chk(mem_wr_en && mem_wr_addr == it.addr && mem_wr_data == it.data, "R7",
                  "write-through", mem_wr_data, it.data);
              if (mem_wr_en) backing[mem_wr_addr] = mem_wr_data;
            end else begin
              chk(!mem_wr_en, "R7", "stray write", 32'(mem_wr_en), 32'h0);
            end
          end
        end else if (q.size() != 0 && cyc >= q[0].acc && cpu_ready) begin
          q[0].stall_bad = 1'b1;
        end
      end
    end
  end

  initial begin
    #(20 * 60000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired: actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NWORDS; a++) begin
      golden[a]  = 32'h5A000000 | (32'(a) * 32'h00001001);
      backing[a] = golden[a];
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cpu_ready && !cpu_rvalid && !mem_req && !mem_wr_en, "R1", "reset outputs",
        {28'h0, cpu_ready, cpu_rvalid, mem_req, mem_wr_en}, 32'h8);
    check_counts(0, 0, "R1");
    rst = 1'b0;

    // set 1 (index bits [3:2]=01): fill order P,Q,R,S go to empty ways 0..3 (R5)
    access(12'h004, 0, 0, 0, "R5");
    access(12'h014, 0, 0, 0, "R5");
    access(12'h024, 0, 0, 0, "R5");
    access(12'h034, 0, 0, 0, "R5");
    access(12'h005, 0, 0, 1, "R2");   // hit P: ages become 0,3,2,1 (R4)
    access(12'h044, 0, 0, 0, "R5");   // miss: oldest is Q in way 1
    access(12'h006, 0, 0, 1, "R4");   // P still present
    access(12'h026, 0, 0, 1, "R4");
    access(12'h037, 0, 0, 1, "R4");
    access(12'h045, 0, 0, 1, "R4");
    access(12'h015, 0, 0, 0, "R5");   // Q was evicted
    drain();
    check_counts(5, 6, "R4");

    // set 0: saturation case (R6)
    access(12'h000, 0, 0, 0, "R6");
    access(12'h010, 0, 0, 0, "R6");
    access(12'h020, 0, 0, 0, "R6");
    access(12'h030, 0, 0, 0, "R6");
    for (int i = 0; i < 5; i++) access(12'h031, 0, 0, 1, "R6");
    access(12'h040, 0, 0, 0, "R6");   // ways 0 and 1 tied at cap: way 0 goes
    access(12'h011, 0, 0, 1, "R6");   // way 1 survives (wrapping would evict it)
    access(12'h002, 0, 0, 0, "R6");   // way 0 line gone
    drain();
    check_counts(11, 12, "R6");

    // write-through, hit and miss (R7)
    access(12'h036, 1, 32'hDEADBEEF, 1, "R7");
    access(12'h036, 0, 0, 1, "R7");
    access(12'h0F8, 1, 32'h0BADF00D, 0, "R7");
    access(12'h0F8, 0, 0, 1, "R7");
    access(12'h0F9, 0, 0, 1, "R8");
    drain();
    check_counts(15, 13, "R7");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule